// File: doc/BRIEF.md
# DMA Channel Interrupt Aggregator

This block gathers interrupt events from a bank of DMA channels and turns them into one level-sensitive interrupt line. Every channel can raise three kinds of event: a transfer-complete pulse and two independent error pulses. Each kind has its own bit per channel in three registers. The first is a latched raw event register. The second is an enable mask. The third is a read-only masked view, which is the raw register ANDed with the mask.

A summary word ORs the three masked views channel by channel. The interrupt output is high whenever that word is non-zero. Software finds the channels to service by scanning the summary word from its lowest set bit upward. It acknowledges an event by writing a one to the matching bit of the raw register for that event kind. Zero bits in the write leave their events alone.

The same register port also exposes two more registers. One is a live channel-busy word supplied by the data movers. The other is a plain channel-priority word that software may program. The data movers only deliver one-cycle event pulses and busy levels.

Top module: `dma_irq_agg`

## Requirements
- R1: After reset all raw event bits, all mask bits and the priority word are zero, `irq_o` is low, and every register reads zero while `ch_busy` is zero.
- R2: The complete, error-1 and error-2 masks are written and read at offsets 0x018, 0x020 and 0x024. Only the low NUM_CH bits are stored, and the bits above them read as zero. A mask bit of 1 enables that channel.
- R3: Writing to the raw registers at 0x600 (complete), 0x608 (error 1) or 0x610 (error 2) clears each bit written as 1. Bits written as 0 keep their value.
- R4: A one-cycle pulse on bit i of an event input sets bit i of that kind's raw register, and the bit stays set until it is cleared. If a pulse and a clear of the same bit arrive in the same cycle, the bit ends up set.
- R5: The masked status registers at 0x004 (complete), 0x00C (error 1) and 0x010 (error 2) read as raw AND mask for their kind.
- R6: The summary word at 0x000 has bit i set exactly when channel i has at least one raw event whose mask bit is set.
- R7: `irq_o` is high whenever the summary word is non-zero. It falls in the cycle after the last enabled event is cleared or masked off, even though the raw bit may still be set.
- R8: Offset 0x690 reads the current value of the `ch_busy` input.
- R9: Offset 0x688 is a DATA_W-bit priority word that reads back the last value written. Writing 0 restores equal priority for all channels.
- R10: Reads of any unmapped offset return zero. Writes to the summary and masked-status offsets change no state.
- R11: Read data appears on `reg_rdata` in the cycle after `reg_re` is sampled high, and `reg_rdata` is zero in a cycle after no read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_done | input | NUM_CH | Per-channel transfer-complete pulses |
| evt_err1 | input | NUM_CH | Per-channel error-1 pulses |
| evt_err2 | input | NUM_CH | Per-channel error-2 pulses |
| ch_busy | input | NUM_CH | Per-channel transfer-in-progress levels |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, one cycle after the read strobe |
| irq_o | output | 1 | Level-sensitive combined interrupt |

## Verification
The bench builds the block with NUM_CH = 16, DATA_W = 32 and ADDR_W = 12. These are the widest channel count the summary word is meant for, and they put the top channel (bit 15) and the error-2 kind at the edge of both the mask and the summary word. Because DATA_W exceeds NUM_CH, an all-ones mask write shows that bits 16 to 31 are discarded and read back as zero. The 12-bit address also reaches the highest decoded offset (0x690) and unmapped offsets near the raw registers.

// File: rtl/dma_irq_agg_pkg.sv
package dma_irq_agg_pkg;

    localparam int N_KIND = 3;

    // Byte offsets decoded by software drivers.
    localparam int OFS_SUMMARY  = 'h000;
    localparam int OFS_MSK_DONE = 'h004;
    localparam int OFS_MSK_ERR1 = 'h00C;
    localparam int OFS_MSK_ERR2 = 'h010;
    localparam int OFS_EN_DONE  = 'h018;
    localparam int OFS_EN_ERR1  = 'h020;
    localparam int OFS_EN_ERR2  = 'h024;
    localparam int OFS_RAW_DONE = 'h600;
    localparam int OFS_RAW_ERR1 = 'h608;
    localparam int OFS_RAW_ERR2 = 'h610;
    localparam int OFS_PRIO     = 'h688;
    localparam int OFS_BUSY     = 'h690;

    function automatic int raw_ofs(input int kind);
        case (kind)
            0:       return OFS_RAW_DONE;
            1:       return OFS_RAW_ERR1;
            default: return OFS_RAW_ERR2;
        endcase
    endfunction

    function automatic int en_ofs(input int kind);
        case (kind)
            0:       return OFS_EN_DONE;
            1:       return OFS_EN_ERR1;
            default: return OFS_EN_ERR2;
        endcase
    endfunction

    function automatic int msk_ofs(input int kind);
        case (kind)
            0:       return OFS_MSK_DONE;
            1:       return OFS_MSK_ERR1;
            default: return OFS_MSK_ERR2;
        endcase
    endfunction

endpackage

// File: rtl/dma_irq_kind.sv
module dma_irq_kind #(
    parameter int NUM_CH  = 16,
    parameter int ADDR_W  = 12,
    parameter int RAW_OFS = 'h600,
    parameter int EN_OFS  = 'h018
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] evt,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [NUM_CH-1:0] wr_data,
    output logic [NUM_CH-1:0] raw_o,
    output logic [NUM_CH-1:0] en_o
);

    typedef struct packed {
        logic [NUM_CH-1:0] raw;
        logic [NUM_CH-1:0] en;
    } kind_st_t;

    kind_st_t st_d, st_q;
    logic     clr_hit, en_hit;

    always_comb begin
        st_d    = st_q;
        clr_hit = wr_en && (wr_addr == ADDR_W'(RAW_OFS));
        en_hit  = wr_en && (wr_addr == ADDR_W'(EN_OFS));
        // Clear first, then set: a same-cycle event survives the clear.
        st_d.raw = (st_q.raw & ~(clr_hit ? wr_data : '0)) | evt;
        if (en_hit) begin
            st_d.en = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign raw_o = st_q.raw;
    assign en_o  = st_q.en;

    // R3: bits written as one without a coincident event are gone next cycle.
    a_r3_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_W'(RAW_OFS)) |=> ((raw_o & $past(wr_data & ~evt)) == '0));

    // R4: every pulsed bit is set in the following cycle, clear or not.
    a_r4_event_latches: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt) |=> ((raw_o & $past(evt)) == $past(evt)));

    // R4: without events or clears the raw bits hold.
    a_r4_raw_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!(|evt) && !(wr_en && wr_addr == ADDR_W'(RAW_OFS))) |=> $stable(raw_o));

    // R2: a mask write lands in the next cycle.
    a_r2_mask_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_W'(EN_OFS)) |=> (en_o == $past(wr_data)));

endmodule

// File: rtl/dma_irq_rdmux.sv
module dma_irq_rdmux
    import dma_irq_agg_pkg::*;
#(
    parameter int NUM_CH = 16,
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          rd_en,
    input  logic [ADDR_W-1:0]             rd_addr,
    input  logic [N_KIND-1:0][NUM_CH-1:0] raw,
    input  logic [N_KIND-1:0][NUM_CH-1:0] en,
    input  logic [NUM_CH-1:0]             summary,
    input  logic [NUM_CH-1:0]             busy,
    input  logic [DATA_W-1:0]             prio,
    output logic [DATA_W-1:0]             rdata
);

    logic [DATA_W-1:0] rdata_d, rdata_q;
    logic              hit;

    always_comb begin
        rdata_d = '0;
        hit     = 1'b0;
        if (rd_en) begin
            if (rd_addr == ADDR_W'(OFS_SUMMARY)) begin
                rdata_d = DATA_W'(summary);
                hit     = 1'b1;
            end
            if (rd_addr == ADDR_W'(OFS_PRIO)) begin
                rdata_d = prio;
                hit     = 1'b1;
            end
            if (rd_addr == ADDR_W'(OFS_BUSY)) begin
                rdata_d = DATA_W'(busy);
                hit     = 1'b1;
            end
            for (int k = 0; k < N_KIND; k++) begin
                if (rd_addr == ADDR_W'(raw_ofs(k))) begin
                    rdata_d = DATA_W'(raw[k]);
                    hit     = 1'b1;
                end
                if (rd_addr == ADDR_W'(en_ofs(k))) begin
                    rdata_d = DATA_W'(en[k]);
                    hit     = 1'b1;
                end
                if (rd_addr == ADDR_W'(msk_ofs(k))) begin
                    rdata_d = DATA_W'(raw[k] & en[k]);
                    hit     = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else begin
            rdata_q <= rdata_d;
        end
    end

    assign rdata = rdata_q;

    // R10: unmapped reads return zero.
    a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !hit) |=> (rdata == '0));

    // R11: no read, no data.
    a_r11_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> (rdata == '0));

endmodule

// File: rtl/dma_irq_agg.sv
module dma_irq_agg
    import dma_irq_agg_pkg::*;
#(
    parameter int NUM_CH = 16,
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] evt_done,
    input  logic [NUM_CH-1:0] evt_err1,
    input  logic [NUM_CH-1:0] evt_err2,
    input  logic [NUM_CH-1:0] ch_busy,
    input  logic              reg_we,
    input  logic              reg_re,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_o
);

    logic [N_KIND-1:0][NUM_CH-1:0] evt_all, raw_all, en_all, pend_all;
    logic [NUM_CH-1:0]             summary;
    logic [DATA_W-1:0]             prio_d, prio_q;

    assign evt_all[0] = evt_done;
    assign evt_all[1] = evt_err1;
    assign evt_all[2] = evt_err2;

    for (genvar k = 0; k < N_KIND; k++) begin : g_kind
        dma_irq_kind #(
            .NUM_CH  (NUM_CH),
            .ADDR_W  (ADDR_W),
            .RAW_OFS (raw_ofs(k)),
            .EN_OFS  (en_ofs(k))
        ) i_kind (
            .clk     (clk),
            .rst_n   (rst_n),
            .evt     (evt_all[k]),
            .wr_en   (reg_we),
            .wr_addr (reg_addr),
            .wr_data (reg_wdata[NUM_CH-1:0]),
            .raw_o   (raw_all[k]),
            .en_o    (en_all[k])
        );
        assign pend_all[k] = raw_all[k] & en_all[k];
    end

    always_comb begin
        summary = '0;
        for (int k = 0; k < N_KIND; k++) begin
            summary = summary | pend_all[k];
        end
    end

    assign irq_o = |summary;

    always_comb begin
        prio_d = prio_q;
        if (reg_we && reg_addr == ADDR_W'(OFS_PRIO)) begin
            prio_d = reg_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prio_q <= '0;
        end else begin
            prio_q <= prio_d;
        end
    end

    dma_irq_rdmux #(
        .NUM_CH (NUM_CH),
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) i_rdmux (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (reg_re),
        .rd_addr (reg_addr),
        .raw     (raw_all),
        .en      (en_all),
        .summary (summary),
        .busy    (ch_busy),
        .prio    (prio_q),
        .rdata   (reg_rdata)
    );

    // R9: a priority write is held until the next one.
    a_r9_prio_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_we && reg_addr == ADDR_W'(OFS_PRIO)) |=> $stable(prio_q));

    // R7: with every mask cleared the line stays low.
    a_r7_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (en_all == '0) |-> !irq_o);

endmodule

// File: tb/test_dma_irq_agg.sv
`timescale 1ns/100ps
module test_dma_irq_agg;

    localparam int NUM_CH = 16;
    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NUM_CH-1:0] evt_done = '0, evt_err1 = '0, evt_err2 = '0, ch_busy = '0;
    logic              reg_we = 1'b0, reg_re = 1'b0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic [DATA_W-1:0] reg_wdata = '0;
    logic [DATA_W-1:0] reg_rdata;
    logic              irq_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    dma_irq_agg #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_dma_irq_agg (
        .clk(clk), .rst_n(rst_n),
        .evt_done(evt_done), .evt_err1(evt_err1), .evt_err2(evt_err2),
        .ch_busy(ch_busy), .reg_we(reg_we), .reg_re(reg_re),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_o(irq_o)
    );

    task automatic check(input string req, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input int addr, input logic [DATA_W-1:0] data);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = ADDR_W'(addr); reg_wdata = data;
        @(posedge clk);
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input int addr, output logic [DATA_W-1:0] data);
        @(negedge clk);
        reg_re = 1'b1; reg_addr = ADDR_W'(addr);
        @(posedge clk);
        @(negedge clk);
        reg_re = 1'b0;
        data = reg_rdata;
    endtask

    task automatic pulse(input logic [NUM_CH-1:0] d, input logic [NUM_CH-1:0] e1, input logic [NUM_CH-1:0] e2);
        @(negedge clk);
        evt_done = d; evt_err1 = e1; evt_err2 = e2;
        @(posedge clk);
        @(negedge clk);
        evt_done = '0; evt_err1 = '0; evt_err2 = '0;
    endtask

    task automatic t_reset;
        logic [DATA_W-1:0] v;
        check("R1 irq after reset", {31'b0, irq_o}, 32'h0);
        foreach (v[i]) begin end
        rd('h000, v); check("R1 summary", v, 32'h0);
        rd('h018, v); check("R1 done mask", v, 32'h0);
        rd('h600, v); check("R1 done raw", v, 32'h0);
        rd('h688, v); check("R1 priority", v, 32'h0);
    endtask

    task automatic t_masks;
        logic [DATA_W-1:0] v;
        wr('h018, 32'hFFFF_FFFF);
        rd('h018, v); check("R2 done mask upper bits dropped", v, 32'h0000_FFFF);
        wr('h020, 32'h0000_00A5);
        rd('h020, v); check("R2 err1 mask", v, 32'h0000_00A5);
        wr('h024, 32'h0000_8001);
        rd('h024, v); check("R2 err2 mask", v, 32'h0000_8001);
    endtask

    task automatic t_latch;
        logic [DATA_W-1:0] v;
        pulse(16'h0008, 16'h0002, 16'h8000);
        check("R7 irq high", {31'b0, irq_o}, 32'h1);
        rd('h600, v); check("R4 done raw latched", v, 32'h0008);
        rd('h608, v); check("R4 err1 raw latched", v, 32'h0002);
        rd('h004, v); check("R5 done masked", v, 32'h0008);
        rd('h00C, v); check("R5 err1 masked off", v, 32'h0000);
        rd('h010, v); check("R5 err2 masked", v, 32'h8000);
        rd('h000, v); check("R6 summary", v, 32'h8008);
    endtask

    task automatic t_clear;
        logic [DATA_W-1:0] v;
        wr('h600, 32'h0);
        rd('h600, v); check("R3 zero write keeps raw", v, 32'h0008);
        wr('h600, 32'h0008);
        rd('h600, v); check("R3 done cleared", v, 32'h0000);
        rd('h000, v); check("R6 summary after done clear", v, 32'h8000);
        check("R7 irq still high", {31'b0, irq_o}, 32'h1);
        wr('h610, 32'h8000);
        rd('h000, v); check("R6 summary empty", v, 32'h0000);
        check("R7 irq low with masked raw left", {31'b0, irq_o}, 32'h0);
        rd('h608, v); check("R3 err1 raw untouched", v, 32'h0002);
    endtask

    task automatic t_race;
        logic [DATA_W-1:0] v;
        @(negedge clk);
        evt_done = 16'h0020;
        reg_we = 1'b1; reg_addr = ADDR_W'('h600); reg_wdata = 32'h0020;
        @(posedge clk);
        @(negedge clk);
        evt_done = '0; reg_we = 1'b0;
        rd('h600, v); check("R4 event wins over clear", v, 32'h0020);
        check("R7 irq from race event", {31'b0, irq_o}, 32'h1);
        wr('h018, 32'h0);
        check("R7 irq low after mask off", {31'b0, irq_o}, 32'h0);
        rd('h600, v); check("R7 raw kept while masked", v, 32'h0020);
        wr('h018, 32'hFFFF);
        check("R7 irq back on unmask", {31'b0, irq_o}, 32'h1);
        wr('h600, 32'h0020);
    endtask

    task automatic t_ignored;
        logic [DATA_W-1:0] v;
        pulse(16'h0001, 16'h0, 16'h0);
        wr('h000, 32'hFFFF_FFFF);
        wr('h004, 32'hFFFF_FFFF);
        rd('h600, v); check("R10 status write leaves raw", v, 32'h0001);
        rd('h018, v); check("R10 status write leaves mask", v, 32'h0000_FFFF);
        rd('h604, v); check("R10 unmapped 0x604", v, 32'h0);
        rd('h7FC, v); check("R10 unmapped 0x7FC", v, 32'h0);
        wr('h600, 32'h0001);
    endtask

    task automatic t_busy_prio;
        logic [DATA_W-1:0] v;
        ch_busy = 16'h1234;
        rd('h690, v); check("R8 busy", v, 32'h1234);
        ch_busy = 16'h8001;
        rd('h690, v); check("R8 busy follows input", v, 32'h8001);
        ch_busy = '0;
        wr('h688, 32'hDEAD_BEEF);
        rd('h688, v); check("R9 priority readback", v, 32'hDEAD_BEEF);
        wr('h688, 32'h0);
        rd('h688, v); check("R9 priority equal", v, 32'h0);
    endtask

    task automatic t_read_timing;
        logic [DATA_W-1:0] v;
        rd('h018, v); check("R11 read data next cycle", v, 32'h0000_FFFF);
        @(negedge clk);
        check("R11 idle data zero", reg_rdata, 32'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_masks();
        t_latch();
        t_clear();
        t_race();
        t_ignored();
        t_busy_prio();
        t_read_timing();
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule